// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block does the multiply, high-half multiply, divide and remainder work of a pipelined execute stage, using a loop over several clock cycles instead of a single-cycle array. The earlier stage hands it two operands that are already prepared, plus a function code. The unit copies the operands into its own registers in the cycle it accepts them. It then computes the result and returns it on a one-cycle done strobe.

While an accepted operation is still running, the unit raises a stall request. The pipeline uses it to hold the instruction in execute and to send a bubble, rather than a copy of the instruction, into the following stage. A multiply stops early once the remaining multiplier digits are all zero, so its latency depends on the operand. Divide and remainder always take the same number of cycles. An abort input throws away the operation in flight.

Cycle counting below treats the cycle in which `start_i` is accepted as cycle 1. The operation ends in the cycle in which `done_o` is high.

Top module: `md_unit`

## Requirements
- R1: While reset is active and after reset is released, `stall_o`, `done_o` and `result_o` are all 0 until a start is accepted.
- R2: `fn_i[2:0]` selects the operation. Values 0 to 3 are multiply variants: 0 gives the low half of the product, 1 the high half with both operands signed, 2 the high half with `opa_i` signed and `opb_i` unsigned, and 3 the high half with both unsigned. `fn_i[3]` has no effect.
- R3: Values 4 to 7 of `fn_i[2:0]` are divide variants: 4 is signed quotient, 5 unsigned quotient, 6 signed remainder and 7 unsigned remainder. `opa_i` is the dividend. Quotients are truncated toward zero, and a remainder takes the sign of the dividend.
- R4: When the divisor is zero, the quotient is all ones and the remainder equals the dividend.
- R5: For signed divide of the most negative value by -1, the quotient equals the dividend and the remainder is 0.
- R6: Multiply latency is 2 + ceil(k/2) cycles. Here k is the bit length of the multiplier magnitude: the absolute value of `opb_i` for function 1, and `opb_i` taken as unsigned for functions 0, 2 and 3. This gives a range of 2 to 18.
- R7: Every divide and remainder operation takes exactly 34 cycles.
- R8: `stall_o` is high in every cycle of an operation except its last, is low in the done cycle, and is never high together with `done_o`.
- R9: `done_o` is a single-cycle pulse, and `result_o` holds the result during that cycle. At all other times `result_o` is 0.
- R10: A start request that arrives while an operation is running is ignored. The running operation keeps its latency and its result.
- R11: `abort_i` forces `stall_o` and `done_o` low in the same cycle, even in the start or done cycle. The unit is idle in the next cycle and accepts a new start from then on.
- R12: Changes on `opa_i`, `opb_i` and `fn_i` after the start cycle have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation (taken only when idle) |
| abort_i | input | 1 | Discard the operation in flight |
| fn_i | input | 4 | Function code; bits [2:0] select the operation |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| stall_o | output | 1 | Operation in progress; hold the pipeline |
| done_o | output | 1 | Result valid this cycle |
| result_o | output | 32 | Selected result, 0 outside the done cycle |

## Verification
The hardest situations to reach are the ones that depend on exact timing. One is an abort that lands on the very cycle the result would appear, whether that is the 2-cycle zero-multiplier case or the 34th cycle of a divide. The other is a start pulse that arrives while a long multiply is still running. The bench computes each operation's latency from its operands before issuing it. It then schedules the abort or the stray start on a cycle counted relative to that latency, and scrambles the operand inputs on all other busy cycles. A sweep over every pair from a set of edge values, in every function, covers the zero divisor, the signed overflow pair and both ends of the multiply latency range.

// File: rtl/md_pkg.sv
package md_pkg;

   typedef enum logic [2:0] {
      OP_MUL    = 3'd0,
      OP_MULH   = 3'd1,
      OP_MULHSU = 3'd2,
      OP_MULHU  = 3'd3,
      OP_DIV    = 3'd4,
      OP_DIVU   = 3'd5,
      OP_REM    = 3'd6,
      OP_REMU   = 3'd7
   } md_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MUL  = 2'd1,
      ST_DIV  = 2'd2
   } md_state_e;

   function automatic logic op_is_div(input logic [2:0] op);
      return op[2];
   endfunction

   // first operand treated as two's complement
   function automatic logic op_a_signed(input logic [2:0] op);
      return (op == OP_MULH) || (op == OP_MULHSU) || (op == OP_DIV) || (op == OP_REM);
   endfunction

   // second operand treated as two's complement
   function automatic logic op_b_signed(input logic [2:0] op);
      return (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
   endfunction

   // multiply variant returning the upper half of the product
   function automatic logic op_high_half(input logic [2:0] op);
      return (op != OP_MUL);
   endfunction

   // divide variant returning the remainder
   function automatic logic op_want_rem(input logic [2:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl #(
   parameter int XLEN = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic abort_i,
   input  logic is_div_i,
   input  logic mul_last_i,
   output logic accept_o,
   output logic step_o,
   output logic stall_o,
   output logic done_o
);
   import md_pkg::*;

   localparam int CW = $clog2(XLEN + 1);

   md_state_e       state_q, state_d;
   logic [CW-1:0]   cnt_q, cnt_d;
   logic            busy;
   logic            fin;

   assign busy = (state_q != ST_IDLE);

   always_comb begin
      fin = 1'b0;
      if (state_q == ST_MUL) fin = mul_last_i;
      if (state_q == ST_DIV) fin = (cnt_q == CW'(XLEN));
   end

   assign accept_o = !busy && start_i && !abort_i;
   assign step_o   = busy && !fin && !abort_i;
   assign stall_o  = accept_o || step_o;
   assign done_o   = fin && !abort_i;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (abort_i) begin
         state_d = ST_IDLE;
      end else if (accept_o) begin
         state_d = is_div_i ? ST_DIV : ST_MUL;
         cnt_d   = '0;
      end else if (fin) begin
         state_d = ST_IDLE;
      end else if (step_o && (state_q == ST_DIV)) begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/md_mul.sv
module md_mul #(
   parameter int XLEN       = 32,
   parameter bit EARLY_EXIT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [XLEN-1:0]   a_i,
   input  logic [XLEN-1:0]   b_i,
   input  logic              a_signed_i,
   input  logic              b_signed_i,
   output logic              last_o,
   output logic [2*XLEN-1:0] prod_o
);
   localparam int PW    = 2 * XLEN;
   localparam int STEPS = XLEN / 2;

   logic [PW-1:0]   mcand_q;
   logic [XLEN-1:0] mplier_q;
   logic [PW-1:0]   acc_q;
   logic            neg_q;

   logic            sa, sb;
   logic [XLEN-1:0] mag_a, mag_b;
   logic [PW-1:0]   addend;

   always_comb begin
      sa    = a_signed_i && a_i[XLEN-1];
      sb    = b_signed_i && b_i[XLEN-1];
      mag_a = sa ? (~a_i + 1'b1) : a_i;
      mag_b = sb ? (~b_i + 1'b1) : b_i;
   end

   // one radix-4 digit (0..3) of the multiplier per step
   always_comb begin
      addend = '0;
      if (mplier_q[0]) addend = addend + mcand_q;
      if (mplier_q[1]) addend = addend + {mcand_q[PW-2:0], 1'b0};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
         neg_q    <= 1'b0;
      end else if (load_i) begin
         mcand_q  <= {{XLEN{1'b0}}, mag_a};
         mplier_q <= mag_b;
         acc_q    <= '0;
         neg_q    <= sa ^ sb;
      end else if (step_i) begin
         acc_q    <= acc_q + addend;
         mcand_q  <= {mcand_q[PW-3:0], 2'b00};
         mplier_q <= {2'b00, mplier_q[XLEN-1:2]};
      end
   end

   generate
      if (EARLY_EXIT) begin : g_early
         assign last_o = (mplier_q == '0);
      end else begin : g_fixed
         localparam int IW = $clog2(STEPS + 1);
         logic [IW-1:0] icnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      icnt_q <= '0;
            else if (load_i)  icnt_q <= '0;
            else if (step_i)  icnt_q <= icnt_q + 1'b1;
         end
         assign last_o = (icnt_q == IW'(STEPS));
      end
   endgenerate

   assign prod_o = neg_q ? (~acc_q + 1'b1) : acc_q;

endmodule

// File: rtl/md_div.sv
module md_div #(
   parameter int XLEN = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic            step_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            signed_i,
   output logic [XLEN-1:0] quo_o,
   output logic [XLEN-1:0] rem_o
);
   logic [XLEN-1:0] quo_q, rem_q, dvsr_q;
   logic            negq_q, negr_q, dz_q;

   logic            sa, sb;
   logic [XLEN-1:0] mag_a, mag_b;
   logic [XLEN:0]   trial, diff;
   logic            qbit;

   always_comb begin
      sa    = signed_i && a_i[XLEN-1];
      sb    = signed_i && b_i[XLEN-1];
      mag_a = sa ? (~a_i + 1'b1) : a_i;
      mag_b = sb ? (~b_i + 1'b1) : b_i;
   end

   // restoring step: bring down one dividend bit, try a subtract
   always_comb begin
      trial = {rem_q, quo_q[XLEN-1]};
      diff  = trial - {1'b0, dvsr_q};
      qbit  = !diff[XLEN];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         quo_q  <= '0;
         rem_q  <= '0;
         dvsr_q <= '0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
         dz_q   <= 1'b0;
      end else if (load_i) begin
         quo_q  <= mag_a;
         rem_q  <= '0;
         dvsr_q <= mag_b;
         negq_q <= sa ^ sb;
         negr_q <= sa;
         dz_q   <= (b_i == '0);
      end else if (step_i) begin
         rem_q  <= qbit ? diff[XLEN-1:0] : trial[XLEN-1:0];
         quo_q  <= {quo_q[XLEN-2:0], qbit};
      end
   end

   always_comb begin
      if (dz_q)        quo_o = '1;
      else if (negq_q) quo_o = ~quo_q + 1'b1;
      else             quo_o = quo_q;
      rem_o = negr_q ? (~rem_q + 1'b1) : rem_q;
   end

endmodule

// File: rtl/md_unit.sv
module md_unit #(
   parameter int XLEN       = 32,
   parameter bit EARLY_EXIT = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic            abort_i,
   input  logic [3:0]      fn_i,
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opb_i,
   output logic            stall_o,
   output logic            done_o,
   output logic [XLEN-1:0] result_o
);
   import md_pkg::*;

   localparam int PW = 2 * XLEN;

   if ((XLEN < 4) || ((XLEN % 2) != 0)) begin : g_bad_xlen
      $error("md_unit: XLEN must be even and at least 4");
   end

   logic [2:0]      op_q;
   logic            accept, step, mul_last;
   logic [PW-1:0]   prod;
   logic [XLEN-1:0] quo, rem;
   logic [XLEN-1:0] res;
   logic            unused_fn;

   assign unused_fn = fn_i[3];

   md_ctrl #(.XLEN(XLEN)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .abort_i    (abort_i),
      .is_div_i   (op_is_div(fn_i[2:0])),
      .mul_last_i (mul_last),
      .accept_o   (accept),
      .step_o     (step),
      .stall_o    (stall_o),
      .done_o     (done_o)
   );

   md_mul #(.XLEN(XLEN), .EARLY_EXIT(EARLY_EXIT)) u_mul (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (accept && !op_is_div(fn_i[2:0])),
      .step_i     (step && !op_is_div(op_q)),
      .a_i        (opa_i),
      .b_i        (opb_i),
      .a_signed_i (op_a_signed(fn_i[2:0])),
      .b_signed_i (op_b_signed(fn_i[2:0])),
      .last_o     (mul_last),
      .prod_o     (prod)
   );

   md_div #(.XLEN(XLEN)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (accept && op_is_div(fn_i[2:0])),
      .step_i   (step && op_is_div(op_q)),
      .a_i      (opa_i),
      .b_i      (opb_i),
      .signed_i (op_a_signed(fn_i[2:0])),
      .quo_o    (quo),
      .rem_o    (rem)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     op_q <= '0;
      else if (accept) op_q <= fn_i[2:0];
   end

   always_comb begin
      if (op_is_div(op_q))         res = op_want_rem(op_q) ? rem : quo;
      else if (op_high_half(op_q)) res = prod[PW-1:XLEN];
      else                         res = prod[XLEN-1:0];
   end

   assign result_o = done_o ? res : '0;

endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
   parameter int XLEN = 32
) (
   input logic clk_i,
   input logic rst_ni,
   input logic start_i,
   input logic abort_i,
   input logic div_i,
   input logic stall_o,
   input logic done_o
);
   localparam int AW      = $clog2(XLEN + 3) + 1;
   localparam int DIV_LAT = XLEN + 2;
   localparam int MUL_MAX = XLEN / 2 + 2;

   logic          busy_q, div_q;
   logic [AW-1:0] age_q;

   // port-level occupancy model; age_q is the cycle number within the op
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         div_q  <= 1'b0;
         age_q  <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
      end else if (busy_q && done_o) begin
         busy_q <= 1'b0;
      end else if (!busy_q && start_i) begin
         busy_q <= 1'b1;
         div_q  <= div_i;
         age_q  <= AW'(2);
      end else if (busy_q) begin
         age_q  <= age_q + 1'b1;
      end
   end

   p_div_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && div_q && done_o) |-> (age_q == AW'(DIV_LAT)));

   p_mul_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !div_q && done_o) |-> ((age_q >= AW'(2)) && (age_q <= AW'(MUL_MAX))));

   p_busy_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !done_o && !abort_i) |-> stall_o);

   p_stall_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !stall_o);

   p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_abort_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_i |-> (!stall_o && !done_o));

   p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && !start_i) |-> (!stall_o && !done_o));

endmodule

bind md_unit md_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .abort_i (abort_i),
   .div_i   (fn_i[2]),
   .stall_o (stall_o),
   .done_o  (done_o)
);

// File: tb/md_unit_tb.sv
`timescale 1ns/1ps
module md_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        abort = 1'b0;
   logic [3:0]  fn = '0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        stall, done;
   logic [31:0] res;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   md_unit u_dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .start_i  (start),
      .abort_i  (abort),
      .fn_i     (fn),
      .opa_i    (opa),
      .opb_i    (opb),
      .stall_o  (stall),
      .done_o   (done),
      .result_o (res)
   );

   always #4 clk = ~clk;

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 190000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, act=%0d exp<190000", cycles);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_res(input logic [2:0] op,
                                           input logic [31:0] a, input logic [31:0] b);
      logic [63:0]        pu;
      logic signed [63:0] ps;
      logic signed [31:0] sa, sb, q;
      sa = a;
      sb = b;
      case (op)
         3'd0: begin pu = {32'b0, a} * {32'b0, b}; return pu[31:0]; end
         3'd1: begin ps = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}); return ps[63:32]; end
         3'd2: begin ps = $signed({{32{a[31]}}, a}) * $signed({32'b0, b}); return ps[63:32]; end
         3'd3: begin pu = {32'b0, a} * {32'b0, b}; return pu[63:32]; end
         3'd4: begin
            if (b == 0) return 32'hffff_ffff;
            if (a == 32'h8000_0000 && b == 32'hffff_ffff) return a;
            q = sa / sb;
            return q;
         end
         3'd5: return (b == 0) ? 32'hffff_ffff : a / b;
         3'd6: begin
            if (b == 0) return a;
            if (a == 32'h8000_0000 && b == 32'hffff_ffff) return 32'h0;
            q = sa % sb;
            return q;
         end
         default: return (b == 0) ? a : a % b;
      endcase
   endfunction

   function automatic int exp_lat(input logic [2:0] op, input logic [31:0] b);
      logic [31:0] m;
      int bl;
      if (op[2]) return 34;
      m  = (op == 3'd1 && b[31]) ? (~b + 1) : b;
      bl = 0;
      for (int i = 0; i < 32; i++) if (m[i]) bl = i + 1;
      return 2 + (bl + 1) / 2;
   endfunction

   // mode 0 plain, 1 scramble inputs while busy (R12), 2 stray starts while busy (R10)
   task automatic run_op(input logic [2:0] op, input logic hi, input logic [31:0] a,
                         input logic [31:0] b, input int mode);
      int          lat;
      int          cyc;
      bit          got;
      logic [31:0] er;
      string       rtag, ltag;
      lat  = exp_lat(op, b);
      er   = exp_res(op, a, b);
      ltag = op[2] ? "R7 latency" : "R6 latency";
      if (op < 4)                                            rtag = "R2 result";
      else if (b == 0)                                       rtag = "R4 result";
      else if (!op[0] && a == 32'h8000_0000 && b == '1)      rtag = "R5 result";
      else                                                   rtag = "R3 result";
      if (mode == 1) rtag = {rtag, " R12"};
      if (mode == 2) rtag = {rtag, " R10"};
      @(negedge clk);
      start = 1'b1; fn = {hi, op}; opa = a; opb = b;
      #1;
      chk(stall === 1'b1 && done === 1'b0, "R8 start-cycle stall", {stall, done}, 2'b10);
      cyc = 1;
      got = 1'b0;
      while (!got && cyc < 60) begin
         @(negedge clk);
         start = 1'b0;
         if (mode == 2 && cyc <= 4 && lat > 7) begin
            start = 1'b1; fn = 4'($urandom); opa = $urandom; opb = $urandom;
         end else if (mode >= 1) begin
            fn = 4'($urandom); opa = $urandom; opb = $urandom;
         end
         #1;
         cyc++;
         if (done === 1'b1) begin
            got = 1'b1;
            chk(cyc == lat, ltag, cyc, lat);
            chk(res === er, rtag, res, er);
            chk(stall === 1'b0, "R8 no stall in done cycle", stall, 0);
         end else begin
            chk(stall === 1'b1, "R8 stall while busy", stall, 1);
            chk(res === 32'h0, "R9 result idle zero", res, 0);
         end
      end
      if (!got) chk(1'b0, "R9 done never seen", 0, 1);
      start = 1'b0;
   endtask

   // abort on cycle 'at' of an operation (1 = start cycle)
   task automatic abort_case(input logic [2:0] op, input logic [31:0] a,
                             input logic [31:0] b, input int at);
      @(negedge clk);
      start = 1'b1; fn = {1'b0, op}; opa = a; opb = b; abort = (at == 1);
      #1;
      if (at == 1) chk(stall === 1'b0 && done === 1'b0, "R11 abort in start cycle", {stall, done}, 0);
      for (int k = 2; k <= at; k++) begin
         @(negedge clk);
         start = 1'b0;
         abort = (k == at);
         #1;
         if (k == at) begin
            chk(stall === 1'b0 && done === 1'b0, "R11 abort drops stall/done", {stall, done}, 0);
            chk(res === 32'h0, "R11 no result on abort", res, 0);
         end
      end
      @(negedge clk);
      start = 1'b0; abort = 1'b0;
      #1;
      chk(stall === 1'b0 && done === 1'b0, "R11 idle after abort", {stall, done}, 0);
      // R11: a fresh operation right after the abort runs normally
      run_op(3'd5, 1'b0, 32'd1000, 32'd7, 0);
   endtask

   logic [31:0] vals [14];

   initial begin
      vals = '{32'h0, 32'h1, 32'h2, 32'h3, 32'hffff_ffff, 32'hffff_fffe,
               32'h8000_0000, 32'h7fff_ffff, 32'h1234_5678, 32'hfedc_ba98,
               32'h7, 32'h0001_0000, 32'hffff_0001, 32'h0000_0d05};

      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(stall === 1'b0 && done === 1'b0 && res === 32'h0, "R1 during reset",
          {stall, done, res}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(stall === 1'b0 && done === 1'b0 && res === 32'h0, "R1 after reset",
          {stall, done, res}, 0);

      // sweep: every function, every pair of edge values; fn[3] toggles (R2)
      for (int op = 0; op < 8; op++)
         for (int i = 0; i < 14; i++)
            for (int j = 0; j < 14; j++)
               run_op(3'(op), 1'((i + j) & 1), vals[i], vals[j], 0);

      // R12: operand/function inputs scrambled during busy cycles
      for (int op = 0; op < 8; op++) begin
         run_op(3'(op), 1'b0, 32'h8000_0000, 32'hffff_ffff, 1);
         run_op(3'(op), 1'b1, 32'hdead_beef, 32'h0000_1234, 1);
      end

      // R10: stray start requests during long operations
      for (int op = 0; op < 8; op++) begin
         run_op(3'(op), 1'b0, 32'h1357_9bdf, 32'hffff_ffff, 2);
         run_op(3'(op), 1'b0, 32'h8000_0001, 32'h8000_0000, 2);
      end

      // R11: abort at start, mid-run and on the would-be done cycle
      abort_case(3'd4, 32'd100, 32'd3, 1);
      abort_case(3'd4, 32'd100, 32'd3, 6);
      abort_case(3'd6, 32'hffff_ff00, 32'd9, 34);
      abort_case(3'd0, 32'd5, 32'd0, 2);
      abort_case(3'd3, 32'd5, 32'hffff_ffff, 18);
      abort_case(3'd1, 32'd5, 32'h0000_00ff, 3);

      // random operands with varied multiplier lengths (R2, R3, R6)
      for (int n = 0; n < 400; n++) begin
         logic [31:0] ra, rb;
         ra = $urandom;
         rb = $urandom >> ($urandom % 32);
         if ($urandom % 2) rb = ~rb;
         run_op(3'($urandom), 1'($urandom), ra, rb, int'($urandom % 2));
      end

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule